// File: doc/BRIEF.md
# Double-Buffered DAC Command Decoder

This block sits behind a serial bus receiver and turns complete 16-bit command words into the register state of a 12-bit voltage DAC. Each word carries a 4-bit command in its upper nibble and a 12-bit payload below it. The block keeps a staging register, an output (DAC) register and a 2-bit power mode. From these it drives the code that goes to the resistor string, an enable for the output buffer, and three select lines for the output termination.

Software can load both registers at once. It can stage a value and commit it later. It can also stage a new value while the previously staged value is committed in the same write. A read command raises a one-cycle strobe so that the bus front end can ship out the readback word. That word packs the power mode above the current DAC code and always reflects the register state of the current cycle.

Top module: `dac_cmd_regs`

## Requirements
- R1: A valid word with command nibble 4'b1100 writes the payload into both registers, and dac_code shows it on the following cycle.
- R2: Command 4'b1101 writes the payload into the staging register only, and dac_code keeps its value.
- R3: Command 4'b1110 writes the payload into the staging register while the DAC register takes the staging value held before this write.
- R4: Command 4'b1111 copies the staging register into the DAC register. Its payload is ignored and the staging register is left unchanged.
- R5: Command nibble 2'b10 in bits [15:14] is a read request. It pulses rd_strobe high for exactly one cycle and changes no register.
- R6: Command nibble 2'b01 in bits [15:14] sets the power mode from payload bits [11:10]: 00 powered up, 01 powered down and floating, 10 powered down with a 1k pull to ground, 11 powered down with a 100k pull to ground.
- R7: In any power-down mode buf_en is low and both registers keep their contents and can still be loaded. Returning to mode 00 raises buf_en, and dac_code shows the held DAC register.
- R8: Reset clears both registers to zero and sets the power mode to 11, so buf_en is low and term_100k is high.
- R9: Command nibble 2'b00 in bits [15:14] changes no state.
- R10: rd_word equals {2'b00, mode[1:0], dac_code[11:0]} in every cycle.
- R11: term_open, term_1k and term_100k follow modes 01, 10 and 11. At most one is high at a time, and all are low while buf_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | cmd_word holds a complete command this cycle |
| cmd_word | input | 16 | Command nibble [15:12] and payload [11:0] |
| dac_code | output | 12 | Current DAC register |
| buf_en | output | 1 | Output buffer enable, high only in mode 00 |
| term_open | output | 1 | Output left floating |
| term_1k | output | 1 | 1k termination to ground selected |
| term_100k | output | 1 | 100k termination to ground selected |
| rd_word | output | 16 | Readback word |
| rd_strobe | output | 1 | One-cycle pulse after a read request |

## Verification
The staging register has no port of its own. Its content is exposed by following each staging write with a commit command, so the tests can tell a staging-only load apart from a load of both registers. The commit sequences are run with a payload that differs from the staged value, which shows that the commit ignores its payload. The staging write with a simultaneous commit is applied after a different value has been staged, which separates "old staged value" from "new payload". All four power modes are stepped through with a load performed while powered down, and no-op and read words are placed between loads to show that they leave the readback word unchanged.

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs #(
  parameter int DW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [DW+3:0]   cmd_word,
  output logic [DW-1:0]   dac_code,
  output logic            buf_en,
  output logic            term_open,
  output logic            term_1k,
  output logic            term_100k,
  output logic [DW+3:0]   rd_word,
  output logic            rd_strobe
);
  localparam int CW = DW + 4;

  logic [3:0]    op;
  logic [DW-1:0] pay;
  logic [DW-1:0] stage_q;
  logic [DW-1:0] dac_q;
  logic [1:0]    mode_q;

  assign op  = cmd_word[CW-1:CW-4];
  assign pay = cmd_word[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q   <= '0;
      dac_q     <= '0;
      mode_q    <= 2'b11;
      rd_strobe <= 1'b0;
    end else begin
      rd_strobe <= cmd_valid && (op[3:2] == 2'b10);
      if (cmd_valid) begin
        case (op)
          4'b1100: begin stage_q <= pay; dac_q <= pay; end
          4'b1101: stage_q <= pay;
          4'b1110: begin stage_q <= pay; dac_q <= stage_q; end
          4'b1111: dac_q <= stage_q;
          4'b0100, 4'b0101, 4'b0110, 4'b0111: mode_q <= pay[DW-1:DW-2];
          default: ;
        endcase
      end
    end
  end

  assign dac_code  = dac_q;
  assign buf_en    = (mode_q == 2'b00);
  assign term_open = (mode_q == 2'b01);
  assign term_1k   = (mode_q == 2'b10);
  assign term_100k = (mode_q == 2'b11);
  assign rd_word   = {2'b00, mode_q, dac_q};
endmodule

module dac_cmd_regs_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [DW+3:0] cmd_word,
  input logic [DW-1:0] dac_code,
  input logic [DW-1:0] stage_q,
  input logic          buf_en,
  input logic          term_open,
  input logic          term_1k,
  input logic          term_100k,
  input logic [DW+3:0] rd_word,
  input logic          rd_strobe
);
  logic [3:0] op;
  assign op = cmd_word[DW+3:DW];

  p_load_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == 4'b1100 |=> dac_code == $past(cmd_word[DW-1:0]));
  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == 4'b1101 |=> $stable(dac_code));
  p_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == 4'b1110 |=> dac_code == $past(stage_q));
  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == 4'b1111 |=> $stable(stage_q));
  p_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op[3:2] == 2'b10 |=> rd_strobe && $stable(rd_word));
  p_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op[3:2] == 2'b01 |=> rd_word[DW+1:DW] == $past(cmd_word[DW-1:DW-2]));
  p_noop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op[3:2] == 2'b00 |=> $stable(rd_word) && $stable(stage_q));
  p_term_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({term_open, term_1k, term_100k}) && (buf_en != (term_open | term_1k | term_100k)));
  p_rdword_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[DW-1:0] == dac_code && rd_word[DW+3:DW+2] == 2'b00);
endmodule

bind dac_cmd_regs dac_cmd_regs_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .dac_code(dac_code), .stage_q(stage_q), .buf_en(buf_en),
  .term_open(term_open), .term_1k(term_1k), .term_100k(term_100k),
  .rd_word(rd_word), .rd_strobe(rd_strobe)
);

// File: tb/sim_dac_cmd_regs.sv
module sim_dac_cmd_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [11:0] dac_code;
  logic        buf_en, term_open, term_1k, term_100k, rd_strobe;
  logic [15:0] rd_word;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  dac_cmd_regs u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .dac_code(dac_code), .buf_en(buf_en), .term_open(term_open),
    .term_1k(term_1k), .term_100k(term_100k), .rd_word(rd_word),
    .rd_strobe(rd_strobe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
    @(negedge clk); cmd_valid = 1'b0; cmd_word = '0;
  endtask

  task automatic chk_mode(input string req, input logic [3:0] exp);
    chk(req, {28'd0, buf_en, term_open, term_1k, term_100k}, {28'd0, exp});
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    chk("R8 dac_code", {20'd0, dac_code}, 32'h0);
    chk_mode("R8 mode", 4'b0001);
    chk("R10 rd_word reset", {16'd0, rd_word}, 32'h3000);
    chk("R5 strobe idle", {31'd0, rd_strobe}, 32'h0);
  endtask

  task automatic t_load_both;
    send(16'h4000);
    chk_mode("R11 powered up", 4'b1000);
    send(16'hC5A5);
    chk("R1 dac_code", {20'd0, dac_code}, 32'h5A5);
    chk("R10 rd_word", {16'd0, rd_word}, 32'h05A5);
  endtask

  task automatic t_stage_commit;
    send(16'hD123);
    chk("R2 dac held", {20'd0, dac_code}, 32'h5A5);
    send(16'hF000);
    chk("R4 commit", {20'd0, dac_code}, 32'h123);
    send(16'hF777);
    chk("R4 payload ignored", {20'd0, dac_code}, 32'h123);
  endtask

  task automatic t_swap;
    send(16'hD321);
    send(16'hE456);
    chk("R3 dac gets old stage", {20'd0, dac_code}, 32'h321);
    send(16'hF000);
    chk("R3 stage holds payload", {20'd0, dac_code}, 32'h456);
  endtask

  task automatic t_read;
    send(16'h8ABC);
    chk("R5 strobe high", {31'd0, rd_strobe}, 32'h1);
    chk("R5 dac unchanged", {20'd0, dac_code}, 32'h456);
    @(negedge clk);
    chk("R5 strobe one cycle", {31'd0, rd_strobe}, 32'h0);
    send(16'hBFFF);
    chk("R5 rd_word unchanged", {16'd0, rd_word}, 32'h0456);
    send(16'hF000);
    chk("R5 stage unchanged", {20'd0, dac_code}, 32'h456);
  endtask

  task automatic t_power;
    send(16'h4400);
    chk_mode("R6 floating", 4'b0100);
    chk("R10 rd_word mode01", {16'd0, rd_word}, 32'h1456);
    send(16'h4800);
    chk_mode("R6 1k", 4'b0010);
    chk("R10 rd_word mode10", {16'd0, rd_word}, 32'h2456);
    send(16'h7C00);
    chk_mode("R6 100k", 4'b0001);
    chk("R7 dac kept", {20'd0, dac_code}, 32'h456);
    send(16'hC789);
    chk("R7 load while down", {20'd0, dac_code}, 32'h789);
    chk_mode("R7 still down", 4'b0001);
    send(16'h4000);
    chk_mode("R7 power up", 4'b1000);
    chk("R7 restore", {16'd0, rd_word}, 32'h0789);
  endtask

  task automatic t_noop;
    send(16'hD222);
    send(16'h0333);
    send(16'h3C00);
    chk("R9 dac unchanged", {20'd0, dac_code}, 32'h789);
    chk_mode("R9 mode unchanged", 4'b1000);
    send(16'hF000);
    chk("R9 stage unchanged", {20'd0, dac_code}, 32'h222);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_both();
    t_stage_commit();
    t_swap();
    t_read();
    t_power();
    t_noop();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule